// File: doc/BRIEF.md
# Six-Requester Bus Arbiter with Fixed, Rotating and Mixed Priority

This block decides which of six bus masters owns a shared bus. Requester 0 is the upstream host bridge, requester 1 is the bridge that contains the arbiter, and requesters 2 to 5 are general masters. Each cycle the block looks at the request lines and the configuration, and hands out at most one grant. It never moves the grant while a transaction is in flight or while the owner holds a lock.

Three priority policies are available. The first is a fixed order chosen from twelve codes. The second is a six-way round robin. The third is a mixed policy in which the two bridges stay on top in a fixed order while the four general masters take turns beneath them. If nobody is eligible, the bus can be parked on the host bridge.

A retry indication makes the current owner step back for a while. This keeps a master that has just been told to retry from winning the bus again at once and thrashing it.

Top module: `bus_arbiter6`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `gnt` is all zeros.
- R2: At most one bit of `gnt` is set in any cycle.
- R3: `gnt` can change only on a clock edge at which `bus_idle` is high. A decision made at an edge is visible on `gnt` right after that edge.
- R4: With `mode` = 0 or 3 (fixed), the order code selects the priority list as follows. Bit 0 selects the bridge pair order: 0 means host (0) before self (1), and 1 means self before host. Let k = code >> 1. Then k mod 3 places the pair at the top, in the middle (after two general masters) or at the bottom. k >= 3 lists the general masters as 5,4,3,2 instead of 2,3,4,5. The highest-listed eligible requester wins.
- R5: Order codes 12 to 15 give exactly the same fixed order as code 0.
- R6: With `mode` = 1 (rotating), priority is a six-way round robin. The most recent winner becomes the lowest priority and the requester after it becomes the highest. After reset, requester 0 is the highest.
- R7: With `mode` = 2 (mixed), requesters 0 and 1 outrank all others, in the pair order given by bit 0 of the order code. Requesters 2 to 5 rotate among themselves, starting with 2 after reset, and the rotation advances only when one of them wins.
- R8: With `park_en` high and no eligible request at an idle, unlocked edge, the grant goes to requester 0.
- R9: While `lock` is high and a grant is held, the grant does not change.
- R10: A `retry` pulse while a grant is held masks the owner from arbitration for exactly 16 decision edges, starting at the next edge.
- R11: The mask ends early when a transfer of a different master completes. A completion is a rise of `bus_idle` while a non-masked master holds the grant. The masked master may then win from the edge after the completion.
- R12: With `park_en` low and no eligible request at an idle, unlocked edge, `gnt` becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 6 | Request lines, bit i from requester i |
| bus_idle | input | 1 | High when no transaction is in progress |
| lock | input | 1 | Current owner holds the bus locked |
| retry | input | 1 | Current owner's transaction was answered with a retry |
| park_en | input | 1 | Park the grant on requester 0 when nobody is eligible |
| mode | input | 2 | 0/3 fixed, 1 rotating, 2 mixed |
| order | input | 4 | Fixed-order code (0..11, 12..15 act as 0) |
| gnt | output | 6 | One-hot-or-zero grant |

## Verification
The assertions check on every cycle the properties that need no history: the grant is single, it is frozen while the bus is busy or locked, parking and release happen when nobody is eligible, and a masked master never receives a new grant while its back-off window (counted by the checker, never beyond 16 cycles) is open. Only the bench's scenarios can show that the right master wins. This covers all twelve fixed orders and their aliases, the rotation sequences in rotating and mixed modes, the exact length of the back-off, and its early end when another master completes a transfer.

// File: rtl/arb6_pkg.sv
package arb6_pkg;

  localparam int NM          = 6;
  localparam int IDX_W       = 3;
  localparam int NUM_OTHER   = 4;
  localparam int FIRST_OTHER = 2;
  localparam int HOST_ID     = 0;
  localparam int SELF_ID     = 1;
  localparam int NUM_CODES   = 12;

  typedef logic [IDX_W-1:0]          idx_t;
  typedef logic [1:0]                oth_t;
  typedef logic [NM-1:0][IDX_W-1:0]  rank_t;

  typedef enum logic [1:0] {
    MODE_FIXED   = 2'd0,
    MODE_ROTATE  = 2'd1,
    MODE_MIXED   = 2'd2,
    MODE_FIXED_B = 2'd3
  } arb_mode_e;

  // Codes beyond the defined set fall back to code 0.
  function automatic logic [3:0] norm_code(logic [3:0] c);
    return (int'(c) >= NUM_CODES) ? 4'd0 : c;
  endfunction

  function automatic logic [NM-1:0] to_onehot(idx_t i);
    logic [NM-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  // Fixed order: pair order from bit 0, pair slot from k%3, general
  // master direction from k>=3 (k = code>>1).
  function automatic rank_t fixed_ranks(logic [3:0] code_in);
    logic [3:0] c;
    idx_t       seq [NM];
    idx_t       p_hi, p_lo;
    int         slot, n;
    logic       dsc;
    rank_t      rk;
    c    = norm_code(code_in);
    p_hi = c[0] ? idx_t'(SELF_ID) : idx_t'(HOST_ID);
    p_lo = c[0] ? idx_t'(HOST_ID) : idx_t'(SELF_ID);
    slot = int'(c[3:1]) % 3;
    dsc  = (int'(c[3:1]) >= 3);
    n    = 0;
    rk   = '0;
    for (int k = 0; k < NUM_OTHER; k++) begin
      if (k == 2 * slot) begin
        seq[n]   = p_hi;
        seq[n+1] = p_lo;
        n        = n + 2;
      end
      seq[n] = dsc ? idx_t'(FIRST_OTHER + NUM_OTHER - 1 - k) : idx_t'(FIRST_OTHER + k);
      n      = n + 1;
    end
    if (slot == 2) begin
      seq[NM-2] = p_hi;
      seq[NM-1] = p_lo;
    end
    for (int m = 0; m < NM; m++) rk[seq[m]] = IDX_W'(m);
    return rk;
  endfunction

  // Six-way round robin: the one after the last winner ranks 0.
  function automatic idx_t rot_rank(idx_t i, idx_t last);
    int v;
    v = (int'(i) + NM - int'(last) - 1) % NM;
    return IDX_W'(v);
  endfunction

  // Mixed: bridges on top, general masters rotate beneath.
  function automatic idx_t mixed_rank(idx_t i, logic [3:0] code_in, oth_t last_oth);
    logic [3:0] c;
    int         j, v;
    c = norm_code(code_in);
    if (int'(i) == HOST_ID) return c[0] ? idx_t'(1) : idx_t'(0);
    if (int'(i) == SELF_ID) return c[0] ? idx_t'(0) : idx_t'(1);
    j = int'(i) - FIRST_OTHER;
    v = FIRST_OTHER + ((j + NUM_OTHER - int'(last_oth) - 1) % NUM_OTHER);
    return IDX_W'(v);
  endfunction

endpackage

// File: rtl/arb6_rank.sv
module arb6_rank
  import arb6_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [3:0] code,
  input  idx_t       last,
  input  oth_t       last_oth,
  output rank_t      rank
);

  rank_t fixed_rk;
  assign fixed_rk = fixed_ranks(code);

  for (genvar g = 0; g < NM; g++) begin : g_rank
    assign rank[g] = (arb_mode_e'(mode) == MODE_ROTATE) ? rot_rank(idx_t'(g), last) :
                     (arb_mode_e'(mode) == MODE_MIXED)  ? mixed_rank(idx_t'(g), code, last_oth) :
                                                          fixed_rk[g];
  end

endmodule

// File: rtl/arb6_pick.sv
module arb6_pick
  import arb6_pkg::*;
(
  input  rank_t         rank,
  input  logic [NM-1:0] elig,
  output logic          found,
  output idx_t          win
);

  idx_t best;

  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '1;
    for (int m = 0; m < NM; m++) begin
      if (elig[m] && (!found || rank[m] < best)) begin
        found = 1'b1;
        win   = idx_t'(m);
        best  = rank[m];
      end
    end
  end

endmodule

// File: rtl/arb6_backoff.sv
module arb6_backoff
  import arb6_pkg::*;
#(
  parameter int BACKOFF = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retry,
  input  logic          bus_idle,
  input  logic [NM-1:0] gnt,
  output logic [NM-1:0] mask_vec,
  output logic          mask_on,
  output logic          set_ev,
  output logic          clr_ev
);

  localparam int CNT_W = $clog2(BACKOFF + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [NM-1:0]    who_q;
  logic             idle_q;
  logic             idle_rise;

  assign mask_on   = (cnt_q != '0);
  assign mask_vec  = mask_on ? who_q : '0;
  assign set_ev    = retry && (gnt != '0);
  assign idle_rise = bus_idle && !idle_q;
  assign clr_ev    = mask_on && !set_ev && idle_rise &&
                     (gnt != '0) && ((gnt & who_q) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      who_q  <= '0;
      idle_q <= 1'b1;
    end else begin
      idle_q <= bus_idle;
      if (set_ev) begin
        cnt_q <= CNT_W'(BACKOFF);
        who_q <= gnt;
      end else if (clr_ev) begin
        cnt_q <= '0;
      end else if (mask_on) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_arbiter6.sv
module bus_arbiter6
  import arb6_pkg::*;
#(
  parameter int BACKOFF = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic          bus_idle,
  input  logic          lock,
  input  logic          retry,
  input  logic          park_en,
  input  logic [1:0]    mode,
  input  logic [3:0]    order,
  output logic [NM-1:0] gnt
);

  logic [NM-1:0] gnt_q;
  idx_t          last_q;
  oth_t          lo_q;
  rank_t         rank;
  logic [NM-1:0] mask_vec;
  logic          mask_on;
  logic          set_ev;
  logic          clr_ev;
  logic [NM-1:0] elig;
  logic          found;
  idx_t          win;
  logic          hold;
  logic          grant_upd;
  logic [NM-1:0] gnt_nxt;

  arb6_rank u_rank (
    .mode     (mode),
    .code     (order),
    .last     (last_q),
    .last_oth (lo_q),
    .rank     (rank)
  );

  arb6_backoff #(.BACKOFF(BACKOFF)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .retry    (retry),
    .bus_idle (bus_idle),
    .gnt      (gnt_q),
    .mask_vec (mask_vec),
    .mask_on  (mask_on),
    .set_ev   (set_ev),
    .clr_ev   (clr_ev)
  );

  assign elig = req & ~mask_vec;

  arb6_pick u_pick (
    .rank  (rank),
    .elig  (elig),
    .found (found),
    .win   (win)
  );

  assign hold      = lock && (gnt_q != '0);
  assign grant_upd = bus_idle && !hold;
  assign gnt_nxt   = found   ? to_onehot(win) :
                     park_en ? to_onehot(idx_t'(HOST_ID)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= idx_t'(NM - 1);
      lo_q   <= oth_t'(NUM_OTHER - 1);
    end else if (grant_upd) begin
      gnt_q <= gnt_nxt;
      if (found) begin
        last_q <= win;
        if (int'(win) >= FIRST_OTHER) lo_q <= oth_t'(int'(win) - FIRST_OTHER);
      end
    end
  end

  assign gnt = gnt_q;

endmodule

// File: rtl/bus_arbiter6_chk.sv
module bus_arbiter6_chk
  import arb6_pkg::*;
#(
  parameter int BACKOFF = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] req,
  input logic [NM-1:0] gnt,
  input logic          bus_idle,
  input logic          lock,
  input logic          park_en,
  input logic [NM-1:0] mask_vec,
  input logic          mask_on,
  input logic          set_ev
);

  int unsigned win_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          win_cnt <= 0;
    else if (set_ev)     win_cnt <= 0;
    else if (mask_on)    win_cnt <= win_cnt + 1;
    else                 win_cnt <= 0;
  end

  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_busy_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> $stable(gnt));

  p_lock_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && gnt != '0) |=> $stable(gnt));

  p_park_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (park_en && bus_idle && !lock && (req & ~mask_vec) == '0) |=> gnt == NM'(1));

  p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!park_en && bus_idle && !lock && (req & ~mask_vec) == '0) |=> gnt == '0);

  p_mask_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_on && bus_idle && !lock) |=> (gnt & $past(mask_vec)) == '0);

  p_backoff_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_on |-> win_cnt < BACKOFF);

endmodule

bind bus_arbiter6 bus_arbiter6_chk #(.BACKOFF(BACKOFF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .gnt      (gnt),
  .bus_idle (bus_idle),
  .lock     (lock),
  .park_en  (park_en),
  .mask_vec (mask_vec),
  .mask_on  (mask_on),
  .set_ev   (set_ev)
);

// File: tb/bus_arbiter6_bench.sv
module bus_arbiter6_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] req;
  logic       bus_idle, lock, retry, park_en;
  logic [1:0] mode;
  logic [3:0] order;
  logic [5:0] gnt;

  int n_tot  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bus_arbiter6 u_bus_arbiter6 (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle), .lock(lock),
    .retry(retry), .park_en(park_en), .mode(mode), .order(order), .gnt(gnt)
  );

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; bus_idle = 1'b1; lock = 1'b0; retry = 1'b0;
    park_en = 1'b0; mode = 2'd0; order = 4'd0;
    step(); step();
    chk("R1 in reset", gnt, 6'b0);
    rst_n = 1'b1;
    step();
    chk("R1 after reset", gnt, 6'b0);
  endtask

  // Slot-based restatement of the fixed order list.
  function automatic logic [5:0] exp_fixed(logic [3:0] code, logic [5:0] r);
    int c, pslot, lst[6], oi;
    c = (code > 11) ? 0 : int'(code);
    pslot = 2 * ((c / 2) % 3);
    lst[pslot]     = (c % 2) ? 1 : 0;
    lst[pslot + 1] = (c % 2) ? 0 : 1;
    oi = 0;
    for (int s = 0; s < 6; s++) begin
      if (s != pslot && s != pslot + 1) begin
        lst[s] = (c >= 6) ? 5 - oi : 2 + oi;
        oi++;
      end
    end
    for (int s = 0; s < 6; s++) if (r[lst[s]]) return 6'(1) << lst[s];
    return 6'b0;
  endfunction

  task automatic t_fixed();
    logic [5:0] pats [5] = '{6'b111111, 6'b111100, 6'b000011, 6'b101010, 6'b010100};
    do_reset();
    for (int code = 0; code < 16; code++) begin
      for (int p = 0; p < 5; p++) begin
        order = 4'(code); req = pats[p]; mode = (code % 2) ? 2'd3 : 2'd0;
        step();
        chk(code < 12 ? "R4 fixed order" : "R5 alias code", gnt, exp_fixed(4'(code), pats[p]));
      end
    end
    order = 4'd13; req = 6'b000011; step();
    chk("R5 code 13 as 0", gnt, 6'b000001);
  endtask

  task automatic t_rotate();
    int seq [7] = '{0, 1, 2, 3, 4, 5, 0};
    int sp  [3] = '{2, 5, 2};
    do_reset();
    mode = 2'd1; req = 6'b111111;
    for (int k = 0; k < 7; k++) begin
      step();
      chk("R6 full rotation", gnt, 6'(1) << seq[k]);
    end
    do_reset();
    mode = 2'd1; req = 6'b100100;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R6 sparse rotation", gnt, 6'(1) << sp[k]);
    end
  endtask

  task automatic t_mixed();
    int seq [5] = '{2, 3, 4, 5, 2};
    do_reset();
    mode = 2'd2; order = 4'd0; req = 6'b111100;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R7 others rotate", gnt, 6'(1) << seq[k]);
    end
    req = 6'b111111; step(); chk("R7 host on top", gnt, 6'b000001);
    step(); chk("R7 host stays on top", gnt, 6'b000001);
    req = 6'b111110; step(); chk("R7 self above others", gnt, 6'b000010);
    req = 6'b111100; step(); chk("R7 rotation resumes", gnt, 6'b001000);
    order = 4'd1; req = 6'b000011; step(); chk("R7 pair order bit", gnt, 6'b000010);
  endtask

  task automatic t_busy_hold();
    do_reset();
    req = 6'b000100; step(); chk("R3 first grant", gnt, 6'b000100);
    bus_idle = 1'b0; req = 6'b000001;
    for (int k = 0; k < 3; k++) begin
      step(); chk("R3 frozen while busy", gnt, 6'b000100);
    end
    bus_idle = 1'b1; step(); chk("R3 moves when idle", gnt, 6'b000001);
  endtask

  task automatic t_lock();
    do_reset();
    req = 6'b001000; step(); chk("R9 owner granted", gnt, 6'b001000);
    lock = 1'b1; req = 6'b001001;
    step(); chk("R9 locked owner kept", gnt, 6'b001000);
    step(); chk("R9 locked owner kept again", gnt, 6'b001000);
    lock = 1'b0; step(); chk("R9 released to host", gnt, 6'b000001);
  endtask

  task automatic t_park();
    do_reset();
    park_en = 1'b1; step(); chk("R8 park on host", gnt, 6'b000001);
    req = 6'b010000; step(); chk("R8 requester wins over park", gnt, 6'b010000);
    req = 6'b000000; step(); chk("R8 back to park", gnt, 6'b000001);
    park_en = 1'b0; step(); chk("R12 no park releases", gnt, 6'b000000);
  endtask

  task automatic t_retry_window();
    do_reset();
    req = 6'b000100; step(); chk("R10 owner granted", gnt, 6'b000100);
    bus_idle = 1'b0; retry = 1'b1; step();
    retry = 1'b0; bus_idle = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      step();
      if (k == 1)  chk("R10 masked at first edge", gnt, 6'b000000);
      if (k == 16) chk("R10 masked at 16th edge", gnt, 6'b000000);
    end
    step(); chk("R10 mask expired", gnt, 6'b000100);
  endtask

  task automatic t_retry_early();
    do_reset();
    req = 6'b001100; step(); chk("R11 owner granted", gnt, 6'b000100);
    bus_idle = 1'b0; retry = 1'b1; step();
    retry = 1'b0; bus_idle = 1'b1; step(); chk("R11 other master wins", gnt, 6'b001000);
    bus_idle = 1'b0; step(); chk("R11 transfer held", gnt, 6'b001000);
    bus_idle = 1'b1; step(); chk("R11 completion edge", gnt, 6'b001000);
    step(); chk("R11 mask cleared early", gnt, 6'b000100);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; bus_idle = 1'b1; lock = 1'b0; retry = 1'b0;
    park_en = 1'b0; mode = 2'd0; order = 4'd0;
    t_fixed();
    t_rotate();
    t_mixed();
    t_busy_hold();
    t_lock();
    t_park();
    t_retry_window();
    t_retry_early();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

endmodule